// File: doc/BRIEF.md
# GPIO Pin Function and Output Register Block

This block is the register side of a 54-pin general-purpose I/O port, attached to a simple word-wide register bus. Every pin has a 3-bit function code. The code either makes the pin a plain input, makes it a driven output, or hands the pin to one of six alternate peripherals. The alternate functions are chosen by an external mux that reads the `pin_func` output.

Software never rewrites the output latch as a whole word. It drives pins high by writing ones to a set register and drives them low by writing ones to a clear register, so pins owned by other agents are left alone. A read-only level register, one word per 32-pin bank, returns the pin inputs after a two-flop synchroniser.

Writes take effect at the clock edge where `bus_wr_en` is high. A read captures the addressed word into `bus_rdata` at the edge where `bus_rd_en` is high, and `bus_rdata` holds that value until the next read. Address bits [1:0] are ignored.

Top module: `gpio_pinmux_regs`

## Requirements
- R1: After synchronous reset, every function code is 0 (input), every output latch bit is 0, `pin_oe` is all zero and a read of any select word returns 0.
- R2: Pin p's function code is held in select word p/10, at byte offset (p/10)*4 starting at 0x00, in bits (p mod 10)*3 to (p mod 10)*3+2. The select words are read back exactly as written in those bits.
- R3: `pin_func[3p+2:3p]` carries pin p's code. The codes are 0 input, 1 output, 4/5/6/7 alternates 0 to 3, 3 alternate 4 and 2 alternate 5. `pin_oe[p]` is 1 only while the code is 1.
- R4: A write to the set word of bank b (0x1C for pins 0–31, 0x20 for pins 32–53) makes the latch of pin 32b+i equal to 1 for each written 1 in bit i. Written 0 bits leave their latches unchanged. `pin_out` shows the latch from the next cycle.
- R5: A write to the clear word of bank b (0x28 or 0x2C) makes the latch of pin 32b+i equal to 0 for each written 1 in bit i. Written 0 bits leave their latches unchanged.
- R6: The level word of bank b (0x34 or 0x38) returns the pin inputs in bit i for pin 32b+i, delayed by two flops. A change made before capture edge k is first returned by a read captured at edge k+2.
- R7: The following read as zero, and writes to them have no effect: the top 2 bits of each select word, fields of select word 5 beyond pin 53, level bits 22–31 of bank 1, and unmapped addresses.
- R8: The set and clear words always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 54 | Raw pin input levels |
| pin_out | output | 54 | Output latch value per pin |
| pin_oe | output | 54 | Output driver enable per pin |
| pin_func | output | 162 | Function code per pin, 3 bits each |

## Verification
Each select word is written with a distinct dense pattern. Readback and the `pin_func` bus then show whether any field is misplaced across word boundaries, and the all-ones pattern on the last word shows whether bits beyond pin 53 are dropped.

All eight codes are swept on one pin. This tells the output code apart from the alternates and from input.

The set and clear tests use sparse masks, zero masks and full-bank masks on both banks. These separate true bit-wise set/clear behaviour from a whole-word overwrite.

A level change is followed by three back-to-back reads. This pins the synchroniser depth to exactly two flops.

// File: rtl/gpio_regs_pkg.sv
`timescale 1ns/1ps
package gpio_regs_pkg;
    localparam int PINS_DEF   = 54;
    localparam int BUS_W_DEF  = 32;
    localparam int ADDR_W_DEF = 8;
    localparam int FSEL_W_DEF = 3;

    // Word indices (byte offset / 4) of the register groups
    localparam int IDX_SET = 7;
    localparam int IDX_CLR = 10;
    localparam int IDX_LVL = 13;

    typedef enum logic [2:0] {
        FN_INPUT  = 3'd0,
        FN_OUTPUT = 3'd1,
        FN_ALT5   = 3'd2,
        FN_ALT4   = 3'd3,
        FN_ALT0   = 3'd4,
        FN_ALT1   = 3'd5,
        FN_ALT2   = 3'd6,
        FN_ALT3   = 3'd7
    } pin_fn_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_FSEL,
        RG_SET,
        RG_CLR,
        RG_LVL
    } reg_kind_e;

    function automatic logic fn_drives_pad(input pin_fn_e fn);
        return fn == FN_OUTPUT;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int WIDTH  = 54,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= din;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_fsel_regs.sv
`timescale 1ns/1ps
module gpio_fsel_regs #(
    parameter int NUM_PINS = 54,
    parameter int BUS_W    = 32,
    parameter int FSEL_W   = 3,
    parameter int WORD_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [WORD_W-1:0]          wr_word,
    input  logic [BUS_W-1:0]           wdata,
    input  logic [WORD_W-1:0]          rd_word,
    output logic [BUS_W-1:0]           rd_data,
    output logic [NUM_PINS*FSEL_W-1:0] fn_q
);
    localparam int FPW = BUS_W / FSEL_W;

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            localparam logic [WORD_W-1:0] MY_WORD = WORD_W'(p / FPW);
            localparam int MY_LSB = (p % FPW) * FSEL_W;
            always_ff @(posedge clk) begin
                if (rst)
                    fn_q[p*FSEL_W +: FSEL_W] <= '0;
                else if (wr_en && wr_word == MY_WORD)
                    fn_q[p*FSEL_W +: FSEL_W] <= wdata[MY_LSB +: FSEL_W];
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (rd_word == WORD_W'(p / FPW))
                rd_data[(p % FPW)*FSEL_W +: FSEL_W] = fn_q[p*FSEL_W +: FSEL_W];
        end
    end

    // R2
    fsel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(fn_q));
endmodule

// File: rtl/gpio_out_latch.sv
`timescale 1ns/1ps
module gpio_out_latch #(
    parameter int NUM_PINS = 54,
    parameter int BUS_W    = 32,
    parameter int BANK_W   = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                set_en,
    input  logic                clr_en,
    input  logic [BANK_W-1:0]   bank,
    input  logic [BUS_W-1:0]    wdata,
    output logic [NUM_PINS-1:0] q
);
    logic [NUM_PINS-1:0] bank_mask;
    logic [NUM_PINS-1:0] set_mask;
    logic [NUM_PINS-1:0] clr_mask;

    always_comb begin
        bank_mask = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (bank == BANK_W'(p / BUS_W))
                bank_mask[p] = wdata[p % BUS_W];
        end
        set_mask = set_en ? bank_mask : '0;
        clr_mask = clr_en ? bank_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q | set_mask) & ~clr_mask;
    end

    // R4
    set_takes_chk: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((q & $past(set_mask)) == $past(set_mask)));
    // R4
    set_zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clr_en) |=> ((q & ~$past(set_mask)) == ($past(q) & ~$past(set_mask))));
    // R5
    clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((q & $past(clr_mask)) == '0));
    // R5
    latch_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr_en) |=> $stable(q));
endmodule

// File: rtl/gpio_pinmux_regs.sv
`timescale 1ns/1ps
module gpio_pinmux_regs
    import gpio_regs_pkg::*;
#(
    parameter int NUM_PINS    = PINS_DEF,
    parameter int BUS_W       = BUS_W_DEF,
    parameter int ADDR_W      = ADDR_W_DEF,
    parameter int FSEL_W      = FSEL_W_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr_en,
    input  logic                       bus_rd_en,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [BUS_W-1:0]           bus_wdata,
    output logic [BUS_W-1:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]        pin_in,
    output logic [NUM_PINS-1:0]        pin_out,
    output logic [NUM_PINS-1:0]        pin_oe,
    output logic [NUM_PINS*FSEL_W-1:0] pin_func
);
    localparam int FPW            = BUS_W / FSEL_W;
    localparam int NUM_FSEL_WORDS = (NUM_PINS + FPW - 1) / FPW;
    localparam int NUM_BANKS      = (NUM_PINS + BUS_W - 1) / BUS_W;
    localparam int WORD_W         = ADDR_W - 2;
    localparam int BANK_W         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] sub;
    reg_kind_e         kind;
    logic              unused_addr_lsb;

    assign word            = bus_addr[ADDR_W-1:2];
    assign unused_addr_lsb = ^bus_addr[1:0];

    always_comb begin
        kind = RG_NONE;
        sub  = '0;
        if (word < WORD_W'(NUM_FSEL_WORDS)) begin
            kind = RG_FSEL;
            sub  = word;
        end else if (word >= WORD_W'(IDX_SET) && word < WORD_W'(IDX_SET + NUM_BANKS)) begin
            kind = RG_SET;
            sub  = word - WORD_W'(IDX_SET);
        end else if (word >= WORD_W'(IDX_CLR) && word < WORD_W'(IDX_CLR + NUM_BANKS)) begin
            kind = RG_CLR;
            sub  = word - WORD_W'(IDX_CLR);
        end else if (word >= WORD_W'(IDX_LVL) && word < WORD_W'(IDX_LVL + NUM_BANKS)) begin
            kind = RG_LVL;
            sub  = word - WORD_W'(IDX_LVL);
        end
    end

    logic [BUS_W-1:0]    fsel_rd;
    logic [NUM_PINS-1:0] level;
    logic [BUS_W-1:0]    lvl_word;
    logic [BUS_W-1:0]    rd_mux;

    gpio_fsel_regs #(
        .NUM_PINS(NUM_PINS), .BUS_W(BUS_W), .FSEL_W(FSEL_W), .WORD_W(WORD_W)
    ) u_fsel (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr_en && kind == RG_FSEL),
        .wr_word (sub),
        .wdata   (bus_wdata),
        .rd_word (sub),
        .rd_data (fsel_rd),
        .fn_q    (pin_func)
    );

    gpio_out_latch #(
        .NUM_PINS(NUM_PINS), .BUS_W(BUS_W), .BANK_W(BANK_W)
    ) u_latch (
        .clk    (clk),
        .rst    (rst),
        .set_en (bus_wr_en && kind == RG_SET),
        .clr_en (bus_wr_en && kind == RG_CLR),
        .bank   (sub[BANK_W-1:0]),
        .wdata  (bus_wdata),
        .q      (pin_out)
    );

    gpio_sync #(
        .WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (level)
    );

    always_comb begin
        lvl_word = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (sub == WORD_W'(p / BUS_W))
                lvl_word[p % BUS_W] = level[p];
        end
    end

    always_comb begin
        case (kind)
            RG_FSEL: rd_mux = fsel_rd;
            RG_LVL:  rd_mux = lvl_word;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)            bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= rd_mux;
    end

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
            assign pin_oe[p] = fn_drives_pad(pin_fn_e'(pin_func[p*FSEL_W +: FSEL_W]));
        end
    endgenerate

    // R8
    setclr_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && (kind == RG_SET || kind == RG_CLR)) |=> (bus_rdata == '0));
    // R7
    fsel_pad_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && kind == RG_FSEL) |=> (bus_rdata[BUS_W-1:FPW*FSEL_W] == '0));
    // R7
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && kind == RG_NONE) |=> (bus_rdata == '0));
endmodule

// File: tb/gpio_pinmux_regs_test.sv
`timescale 1ns/1ps
module gpio_pinmux_regs_test;
    localparam int NP = 54;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr_en = 1'b0;
    logic          bus_rd_en = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic [NP*3-1:0] pin_func;

    int n_checks = 0;
    int n_fail = 0;
    logic [NP-1:0] exp_out = '0;

    always #2.5 clk = ~clk;

    gpio_pinmux_regs uut (
        .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_func(pin_func)
    );

    task automatic check(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        d = bus_rdata; bus_rd_en = 1'b0;
    endtask

    function automatic logic [31:0] pat(input int w);
        if (w == 5) return 32'hFFFF_FFFF;
        return 32'h9E37_79B9 + 32'h0123_4567 * w;
    endfunction

    function automatic logic [31:0] valid_mask(input int w);
        logic [31:0] m = '0;
        for (int f = 0; f < 10; f++)
            if (w*10 + f < NP) m[f*3 +: 3] = 3'b111;
        return m;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        check(pin_oe == '0, "R1 oe", 192'(pin_oe), 0);
        check(pin_out == '0, "R1 out", 192'(pin_out), 0);
        check(pin_func == '0, "R1 func", 192'(pin_func), 0);
        bus_read(8'h04, d);
        check(d == 0, "R1 fsel word1", 192'(d), 0);
    endtask

    task automatic t_fsel_layout();
        logic [31:0] d;
        logic [NP*3-1:0] ef;
        for (int w = 0; w < 6; w++) bus_write(8'(w*4), pat(w));
        for (int w = 0; w < 6; w++) begin
            bus_read(8'(w*4), d);
            check(d == (pat(w) & valid_mask(w)), "R2/R7 fsel readback", 192'(d), 192'(pat(w) & valid_mask(w)));
        end
        ef = '0;
        for (int p = 0; p < NP; p++) ef[p*3 +: 3] = pat(p/10) >> ((p % 10)*3);
        check(pin_func == ef, "R2 pin_func layout", 192'(pin_func), 192'(ef));
        // unmapped address: write ignored, read zero (R7)
        bus_write(8'h18, 32'h0);
        check(pin_func == ef, "R7 unmapped write ignored", 192'(pin_func), 192'(ef));
        bus_read(8'h18, d);
        check(d == 0, "R7 unmapped read", 192'(d), 0);
        for (int w = 0; w < 6; w++) bus_write(8'(w*4), 32'h0);
    endtask

    task automatic t_codes();
        for (int c = 0; c < 8; c++) begin
            bus_write(8'h04, 32'(c) << 6);
            check(pin_func[36 +: 3] == 3'(c), "R3 pin12 code", 192'(pin_func[36 +: 3]), 192'(c));
            check(pin_oe == ((c == 1) ? (54'd1 << 12) : 54'd0), "R3 oe only for code 1",
                  192'(pin_oe), 192'((c == 1) ? (54'd1 << 12) : 54'd0));
        end
        bus_write(8'h04, 32'h0);
    endtask

    task automatic t_set();
        logic [31:0] d;
        bus_write(8'h1C, 32'h8000_0005); exp_out[31:0] |= 32'h8000_0005;
        check(pin_out == exp_out, "R4 set bank0", 192'(pin_out), 192'(exp_out));
        bus_write(8'h20, 32'h0020_0001); exp_out[53:32] |= 22'h20_0001;
        check(pin_out == exp_out, "R4 set bank1", 192'(pin_out), 192'(exp_out));
        bus_write(8'h1C, 32'h0);
        check(pin_out == exp_out, "R4 zero set no effect", 192'(pin_out), 192'(exp_out));
        bus_read(8'h1C, d);
        check(d == 0, "R8 set reads zero", 192'(d), 0);
        bus_read(8'h20, d);
        check(d == 0, "R8 set bank1 reads zero", 192'(d), 0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        bus_write(8'h28, 32'h0000_0004); exp_out[2] = 1'b0;
        check(pin_out == exp_out, "R5 clear pin2", 192'(pin_out), 192'(exp_out));
        bus_write(8'h2C, 32'h0);
        check(pin_out == exp_out, "R5 zero clear no effect", 192'(pin_out), 192'(exp_out));
        bus_write(8'h2C, 32'hFFFF_FFFF); exp_out[53:32] = '0;
        check(pin_out == exp_out, "R5 clear bank1", 192'(pin_out), 192'(exp_out));
        bus_read(8'h28, d);
        check(d == 0, "R8 clear reads zero", 192'(d), 0);
    endtask

    task automatic t_level();
        logic [31:0] d1, d2, d3;
        logic [NP-1:0] a = 54'h2A_5A5A_C3C3_0FF0;
        logic [NP-1:0] b = 54'h15_A5A5_3C3C_F00F;
        pin_in = a;
        repeat (4) @(negedge clk);
        bus_read(8'h34, d1);
        check(d1 == a[31:0], "R6 level bank0", 192'(d1), 192'(a[31:0]));
        bus_read(8'h38, d1);
        check(d1 == {10'b0, a[53:32]}, "R6/R7 level bank1", 192'(d1), 192'({10'b0, a[53:32]}));
        pin_in = b;
        bus_read(8'h34, d1);
        bus_read(8'h34, d2);
        bus_read(8'h34, d3);
        check(d1 == a[31:0], "R6 sync edge1 old", 192'(d1), 192'(a[31:0]));
        check(d2 == a[31:0], "R6 sync edge2 old", 192'(d2), 192'(a[31:0]));
        check(d3 == b[31:0], "R6 sync edge3 new", 192'(d3), 192'(b[31:0]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fsel_layout();
        t_codes();
        t_set();
        t_clear();
        t_level();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule